// File: doc/BRIEF.md
# Per-Carrier Receive Symbol Error Counter

This block counts carrier events that contain receive symbol errors on a 100 Mb/s physical-layer receive path. It observes three status inputs: carrier sense, receive error and collision. All three are synchronous to the receive clock. A carrier event begins when carrier sense rises and ends when it falls. An event that contains at least one flagged error and no collision adds one to an 8-bit count. That count stops at full scale instead of wrapping.

Management logic reads the count through a single-register request port. A read request returns a 16-bit word one cycle later. The count sits in the low byte and the upper byte is zero. The same read clears the count. A write request on this port is accepted and discarded, so it changes nothing. The port has no back-pressure: it accepts every request in the cycle it is presented. `rsp_valid` pulses for exactly one cycle per read. The requester must take `rsp_data` in that cycle or later, before it issues another read.

Top module: `rx_symerr_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count, `rsp_valid` and `rsp_data` all become zero.
- R2: Bits 15:8 of `rsp_data` are always zero, and bits 7:0 carry the count.
- R3: The count advances only in a cycle where `crs`, `rx_err` are both 1 and `col` is 0.
- R4: A single carrier event (`crs` high continuously) advances the count at most once, however many error cycles it contains.
- R5: A collision cycle inside a carrier event, whether before or at the same time as an error, prevents that event from counting for the rest of the event.
- R6: The count saturates at 255 (0xFF) and stays there until it is read.
- R7: A read (`req`=1, `we`=0) returns the count in `rsp_data` with `rsp_valid`=1 on the following cycle. It also clears the count to zero.
- R8: If a read and a counting error fall in the same cycle, the read returns the count from before the clear, and the count becomes 1.
- R9: A write request (`req`=1, `we`=1) does not change the count, does not raise `rsp_valid` and does not change `rsp_data`.
- R10: After `crs` has been low for at least one cycle, the next carrier event can count again, even if the previous one had already counted or was blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| crs | input | 1 | Carrier present |
| rx_err | input | 1 | Invalid data symbol flagged this cycle |
| col | input | 1 | Collision present |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write request (discarded), 0 = read request |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_data | output | 16 | Read word: zero upper byte, count in low byte |

## Verification
The count is driven with several kinds of carrier event. One kind has a single error cycle and shows that counting works at all. Another has many error cycles and separates per-event counting from per-error counting. Errors with carrier low separate a carrier-qualified count from an unqualified one. Collisions placed before, together with and after the first error show whether blocking applies to the whole event or only to the collision cycle. Back-to-back events with a single idle cycle between them show that the per-event state is released. A run of 300 events separates saturation from wrap-around. A read that lands on a counting cycle separates pre-clear return from post-clear return.

// File: rtl/symerr_pkg.sv
package symerr_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned REG_W_DEF = 16;

  typedef struct packed {
    logic crs;
    logic err;
    logic col;
  } rx_stat_t;
endpackage

// File: rtl/symerr_event_tracker.sv
module symerr_event_tracker
  import symerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rx_stat_t stat_i,
  output logic     inc_o
);
  logic counted_q;
  logic blocked_q;
  logic qual;

  // qualifying error: carrier up, error flagged, no collision now or earlier
  always_comb begin
    qual  = stat_i.crs & stat_i.err & ~stat_i.col;
    inc_o = qual & ~counted_q & ~blocked_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      counted_q <= 1'b0;
      blocked_q <= 1'b0;
    end else if (!stat_i.crs) begin
      counted_q <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      counted_q <= counted_q | inc_o;
      blocked_q <= blocked_q | stat_i.col;
    end
  end

  // R4: a count ends further counting inside the same event
  a_r4_once_per_event: assert property (@(posedge clk) disable iff (rst)
    inc_o |=> !inc_o);

  // R5: a collision inside carrier blocks the next cycle
  a_r5_col_blocks: assert property (@(posedge clk) disable iff (rst)
    (stat_i.crs && stat_i.col) |=> !inc_o);

  // R3: no increment without carrier and error
  a_r3_needs_err: assert property (@(posedge clk) disable iff (rst)
    inc_o |-> (stat_i.crs && stat_i.err && !stat_i.col));
endmodule

// File: rtl/symerr_sat_counter.sv
module symerr_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_full;

  always_comb begin
    at_full = (cnt_q == FULL);
    cnt_d   = cnt_q;
    if (clr_i)
      cnt_d = inc_i ? ONE : '0;
    else if (inc_i && !at_full)
      cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6: full scale is sticky until cleared
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL && !clr_i) |=> (cnt_q == FULL));

  // R3: idle inputs leave the count alone
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

  // R8: clear together with increment lands on one
  a_r8_clr_inc: assert property (@(posedge clk) disable iff (rst)
    (clr_i && inc_i) |=> (cnt_q == ONE));
endmodule

// File: rtl/symerr_read_port.sv
module symerr_read_port #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             rsp_valid_o,
  output logic [REG_W-1:0] rsp_data_o
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic             rd_fire;
  logic [REG_W-1:0] word;
  logic             valid_q;
  logic [REG_W-1:0] data_q;

  assign rd_fire = req_i & ~we_i;
  assign clr_o   = rd_fire;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, cnt_i};
    end else begin : g_nopad
      assign word = cnt_i[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_fire;
      if (rd_fire) data_q <= word;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_data_o  = data_q;

  // R9: a write leaves the response untouched
  a_r9_write_inert: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i) |=> (!rsp_valid_o && $stable(rsp_data_o)));

  // R7: read answered next cycle with the sampled count
  a_r7_read_resp: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> (rsp_valid_o && rsp_data_o[CNT_W-1:0] == $past(cnt_i)));
endmodule

// File: rtl/rx_symerr_counter.sv
module rx_symerr_counter
  import symerr_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned REG_W = REG_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crs,
  input  logic             rx_err,
  input  logic             col,
  input  logic             req,
  input  logic             we,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_data
);
  rx_stat_t         stat;
  logic             inc;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  assign stat = '{crs: crs, err: rx_err, col: col};

  symerr_event_tracker u_track (
    .clk   (clk),
    .rst   (rst),
    .stat_i(stat),
    .inc_o (inc)
  );

  symerr_sat_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .inc_i(inc),
    .clr_i(clr),
    .cnt_o(cnt)
  );

  symerr_read_port #(.CNT_W(CNT_W), .REG_W(REG_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .we_i       (we),
    .cnt_i      (cnt),
    .clr_o      (clr),
    .rsp_valid_o(rsp_valid),
    .rsp_data_o (rsp_data)
  );

  // R2: upper bits of the word are never set
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_data[REG_W-1:CNT_W] == '0);

  // R7: a plain read (no error qualifying) empties the count
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (req && !we && !(crs && rx_err && !col)) |=> (cnt == '0));

  // R1: reset state
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !rsp_valid && rsp_data == '0));
endmodule

// File: tb/rx_symerr_counter_tb.sv
module rx_symerr_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        crs = 1'b0, rx_err = 1'b0, col = 1'b0, req = 1'b0, we = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_counted = 0, m_blocked = 0;
  bit m_valid = 0;
  int m_data = 0;

  always #10 clk = ~clk;

  rx_symerr_counter u_dut (
    .clk(clk), .rst(rst), .crs(crs), .rx_err(rx_err), .col(col),
    .req(req), .we(we), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input bit c, input bit e, input bit k,
                     input bit rq, input bit w, input string tag);
    bit inc, rd;
    crs = c; rx_err = e; col = k; req = rq; we = w;
    inc = c && e && !k && !m_counted && !m_blocked;
    rd  = rq && !w;
    if (rd) begin m_valid = 1; m_data = m_cnt; end
    else m_valid = 0;
    if (rd) m_cnt = inc ? 1 : 0;
    else if (inc && m_cnt < 255) m_cnt = m_cnt + 1;
    if (!c) begin m_counted = 0; m_blocked = 0; end
    else begin m_counted = m_counted | inc; m_blocked = m_blocked | k; end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == m_valid, {tag, " valid"}, rsp_valid, m_valid);
    chk(rsp_data == m_data[15:0], {tag, " data"}, rsp_data, m_data);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  // read and check against a value fixed by the requirements
  task automatic rd_expect(input int exp, input string tag);
    cyc(0, 0, 0, 1, 0, tag);
    chk(rsp_valid == 1'b1 && rsp_data == exp[15:0], {tag, " fixed"}, rsp_data, exp);
    chk(rsp_data[15:8] == 8'h00, "R2 upper byte", rsp_data[15:8], 0);
  endtask

  // carrier event: len cycles, errors on cycles >= err_at, collision at col_at (-1 none)
  task automatic evt(input int len, input int err_at, input int col_at, input string tag);
    for (int i = 0; i < len; i++)
      cyc(1, (err_at >= 0 && i >= err_at), (i == col_at), 0, 0, tag);
    cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_data == 0, "R1 reset outputs", rsp_data, 0);
    rst = 0;
    rd_expect(0, "R1 count after reset");

    evt(4, 1, -1, "R3 single event");
    rd_expect(1, "R3 one event counted");
    rd_expect(0, "R7 read cleared");

    evt(10, 0, -1, "R4 many errors");
    rd_expect(1, "R4 once per event");

    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, "R3 error no carrier");
    rd_expect(0, "R3 no carrier no count");

    evt(6, 3, 1, "R5 col before err");
    evt(6, 2, 2, "R5 col with err");
    rd_expect(0, "R5 collision blocks");
    evt(6, 1, 4, "R5 col after count");
    rd_expect(1, "R5 prior count stays");

    evt(3, 0, -1, "R10 first");
    evt(3, 0, -1, "R10 second");
    evt(3, 0, 0, "R10 blocked");
    evt(3, 0, -1, "R10 after blocked");
    rd_expect(3, "R10 fresh events");

    evt(3, 0, -1, "R9 setup");
    cyc(0, 0, 0, 1, 1, "R9 write");
    cyc(0, 0, 0, 1, 1, "R9 write");
    rd_expect(1, "R9 write no effect");

    for (int i = 0; i < 300; i++) evt(2, 0, -1, "R6 fill");
    rd_expect(255, "R6 saturated");
    rd_expect(0, "R7 clear after sat");

    evt(2, 0, -1, "R8 setup");
    cyc(1, 0, 0, 0, 0, "R8 carrier");
    cyc(1, 1, 0, 1, 0, "R8 read with inc");
    chk(rsp_data == 16'd1, "R8 pre-clear value", rsp_data, 1);
    cyc(0, 0, 0, 0, 0, "R8 end");
    rd_expect(1, "R8 count became one");

    cyc(1, 1, 0, 0, 0, "R1 midevent");
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_cnt = 0; m_counted = 0; m_blocked = 0; m_valid = 0; m_data = 0;
    chk(rsp_valid == 0 && rsp_data == 0, "R1 reset midrun", rsp_data, 0);
    rd_expect(0, "R1 count zero after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule